// File: doc/BRIEF.md
# Debug Port Control With Sleep Handshake

This block holds the control register of a debug port and runs the low-power handshake between the chip's power manager and an external debug tool. The tool writes and reads one eight-bit register. The power manager raises a sleep request, and later a wake request. The block answers each request with a one-cycle grant. When low-power debug is enabled, each grant waits for the tool to act on the synchronization flag. When it is disabled, the grants follow the requests after one cycle.

The register also enables the event pins and selects processor-status mode, which blocks all trace messages. A three-bit code selects the ratio of the trace clock to the system clock. The block produces a single-cycle trace clock enable at that ratio while an external trace enable is high. A new ratio takes effect only at the next divided-clock boundary.

Top module: `dbg_port_ctl`

## Requirements
- R1: After reset, every register field is 0 and reads back as 0x00, with divide-by-1 selected. No grant is issued and the handshake is in its awake idle state.
- R2: The register layout is as follows. Bit 0 is the event port enable, bit 1 is the low-power debug enable, bit 2 is the sync flag, bit 3 is processor-status mode and bits 6:4 are the divider code. Bit 7 reads 0. A write updates bits 0, 1, 3 and 6:4 one cycle later. The event port enable and processor-status mode outputs follow their bits.
- R3: With low-power debug at 1, a sleep request in the awake idle state sets the sync flag, which reads 1 on the next cycle. No grant is issued.
- R4: While entry is pending, a write with bit 2 at 0 produces a one-cycle sleep grant on the next cycle, and the sync flag reads 0 from then on. A write with bit 2 at 1 leaves entry pending.
- R5: With low-power debug at 1, a wake request while asleep leaves the sync flag at 0 and issues no grant. A later write with bit 2 at 1 produces a one-cycle wake grant on the next cycle, and the flag still reads 0.
- R6: With low-power debug at 0, a sleep request in the awake idle state gives a sleep grant on the next cycle. A wake request while asleep gives a wake grant on the next cycle.
- R7: Writing bit 2 while in the awake idle state or while asleep changes neither the sync flag nor the handshake.
- R8: While processor-status mode is 1, the message-allowed output is 0.
- R9: Divider code 000 gives a trace enable pulse on every cycle. Code 001 gives one pulse in every 2 cycles, 011 one in every 4 and 111 one in every 8.
- R10: Any other divider code (010, 100, 101 or 110) gives divide-by-8 and raises the reserved-code output.
- R11: No trace enable pulse occurs while the trace enable input is low. A divider change takes effect only after the next pulse of the old ratio.
- R12: The sleep grant and the wake grant are never high together, and each lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Tool register write strobe |
| reg_wdata | input | 8 | Tool write data |
| reg_rdata | output | 8 | Register readback |
| slp_req | input | 1 | Sleep request from the power manager |
| wake_req | input | 1 | Wake request from the power manager |
| slp_grant | output | 1 | One-cycle sleep entry grant |
| wake_grant | output | 1 | One-cycle sleep exit grant |
| trc_en_in | input | 1 | Trace clock output enable |
| trc_tick | output | 1 | Divided trace clock enable pulse |
| evt_port_en | output | 1 | Event pin functions enabled |
| pstat_mode | output | 1 | Processor-status mode active |
| msg_ok | output | 1 | Trace messages allowed |
| div_rsv | output | 1 | Reserved divider code selected |

## Verification
The assertions assume that the power manager keeps to its protocol. It raises a wake request only after a sleep grant, and it drops its sleep request before the wake. Given that, the sync flag falls only at sleep entry, and two grants never meet. The stimulus lowers each request once it has been observed, and it issues register writes only between those requests. The request lines are also held low during the divider runs.

// File: rtl/dbg_port_pkg.sv
package dbg_port_pkg;

    localparam int unsigned REG_W    = 8;
    localparam int unsigned BIT_EVT  = 0;
    localparam int unsigned BIT_LPD  = 1;
    localparam int unsigned BIT_SYNC = 2;
    localparam int unsigned BIT_PST  = 3;
    localparam int unsigned DIV_LSB  = 4;
    localparam int unsigned DIV_W    = 3;
    localparam int unsigned EXP_W    = 2;

    typedef enum logic [1:0] {
        HS_AWAKE  = 2'd0,
        HS_ENTRY  = 2'd1,
        HS_ASLEEP = 2'd2,
        HS_EXIT   = 2'd3
    } hs_state_e;

    // Divider code to log2 of the ratio; reserved codes fold to the slowest.
    function automatic logic [EXP_W-1:0] div_exp(input logic [DIV_W-1:0] code);
        case (code)
            3'b000:  return 2'd0;
            3'b001:  return 2'd1;
            3'b011:  return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

    function automatic logic div_is_rsv(input logic [DIV_W-1:0] code);
        return !(code == 3'b000 || code == 3'b001 || code == 3'b011 || code == 3'b111);
    endfunction

endpackage

// File: rtl/dbg_hs_fsm.sv
module dbg_hs_fsm
    import dbg_port_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lp_en,
    input  logic slp_req,
    input  logic wake_req,
    input  logic tool_wr,
    input  logic tool_sync,
    output logic sync_flag,
    output logic slp_grant,
    output logic wake_grant
);

    typedef struct packed {
        hs_state_e st;
        logic      sg;
        logic      wg;
    } hs_regs_t;

    hs_regs_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        r_d.sg = 1'b0;
        r_d.wg = 1'b0;
        case (r_q.st)
            HS_AWAKE: begin
                if (slp_req) begin
                    if (lp_en) begin
                        r_d.st = HS_ENTRY;
                    end else begin
                        r_d.st = HS_ASLEEP;
                        r_d.sg = 1'b1;
                    end
                end
            end
            HS_ENTRY: begin
                if (tool_wr && !tool_sync) begin
                    r_d.st = HS_ASLEEP;
                    r_d.sg = 1'b1;
                end
            end
            HS_ASLEEP: begin
                if (wake_req) begin
                    if (lp_en) begin
                        r_d.st = HS_EXIT;
                    end else begin
                        r_d.st = HS_AWAKE;
                        r_d.wg = 1'b1;
                    end
                end
            end
            default: begin
                if (tool_wr && tool_sync) begin
                    r_d.st = HS_AWAKE;
                    r_d.wg = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: HS_AWAKE, sg: 1'b0, wg: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign sync_flag  = (r_q.st == HS_ENTRY);
    assign slp_grant  = r_q.sg;
    assign wake_grant = r_q.wg;

endmodule

// File: rtl/dbg_clk_div.sv
module dbg_clk_div
    import dbg_port_pkg::*;
#(
    parameter int unsigned SEL_W = EXP_W,
    localparam int unsigned CNT_W = (2 ** SEL_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [SEL_W-1:0] exp_sel,
    output logic             tick
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] lim;
    } div_regs_t;

    div_regs_t        r_d, r_q;
    logic [CNT_W-1:0] lim_sel;

    assign lim_sel = ({{(CNT_W-1){1'b0}}, 1'b1} << exp_sel) - {{(CNT_W-1){1'b0}}, 1'b1};
    assign tick    = en && (r_q.cnt == r_q.lim);

    always_comb begin
        r_d = r_q;
        if (!en || tick) begin
            r_d.cnt = '0;
            r_d.lim = lim_sel;
        end else begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/dbg_port_ctl.sv
module dbg_port_ctl
    import dbg_port_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             slp_req,
    input  logic             wake_req,
    output logic             slp_grant,
    output logic             wake_grant,
    input  logic             trc_en_in,
    output logic             trc_tick,
    output logic             evt_port_en,
    output logic             pstat_mode,
    output logic             msg_ok,
    output logic             div_rsv
);

    typedef struct packed {
        logic             evt;
        logic             lpd;
        logic             pst;
        logic [DIV_W-1:0] div;
    } ctl_regs_t;

    ctl_regs_t ctl_d, ctl_q;
    logic      sync_flag;

    always_comb begin
        ctl_d = ctl_q;
        if (reg_wr) begin
            ctl_d.evt = reg_wdata[BIT_EVT];
            ctl_d.lpd = reg_wdata[BIT_LPD];
            ctl_d.pst = reg_wdata[BIT_PST];
            ctl_d.div = reg_wdata[DIV_LSB +: DIV_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    dbg_hs_fsm u_hs (
        .clk        (clk),
        .rst_n      (rst_n),
        .lp_en      (ctl_q.lpd),
        .slp_req    (slp_req),
        .wake_req   (wake_req),
        .tool_wr    (reg_wr),
        .tool_sync  (reg_wdata[BIT_SYNC]),
        .sync_flag  (sync_flag),
        .slp_grant  (slp_grant),
        .wake_grant (wake_grant)
    );

    dbg_clk_div #(.SEL_W(EXP_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (trc_en_in),
        .exp_sel (div_exp(ctl_q.div)),
        .tick    (trc_tick)
    );

    always_comb begin
        reg_rdata                      = '0;
        reg_rdata[BIT_EVT]             = ctl_q.evt;
        reg_rdata[BIT_LPD]             = ctl_q.lpd;
        reg_rdata[BIT_SYNC]            = sync_flag;
        reg_rdata[BIT_PST]             = ctl_q.pst;
        reg_rdata[DIV_LSB +: DIV_W]    = ctl_q.div;
    end

    assign evt_port_en = ctl_q.evt;
    assign pstat_mode  = ctl_q.pst;
    assign msg_ok      = !ctl_q.pst;
    assign div_rsv     = div_is_rsv(ctl_q.div);

endmodule

// File: rtl/dbg_port_ctl_chk.sv
module dbg_port_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] reg_rdata,
    input logic       slp_req,
    input logic       slp_grant,
    input logic       wake_grant,
    input logic       trc_en_in,
    input logic       trc_tick
);

    // R12
    grants_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(slp_grant && wake_grant));

    // R12
    slp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slp_grant |=> !slp_grant);

    // R12
    wake_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_grant |=> !wake_grant);

    // R3
    sync_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_rdata[2]) |-> $past(slp_req));

    // R4
    sync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(reg_rdata[2]) |-> slp_grant);

    // R11
    tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trc_en_in |-> !trc_tick);

endmodule

bind dbg_port_ctl dbg_port_ctl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_rdata  (reg_rdata),
    .slp_req    (slp_req),
    .slp_grant  (slp_grant),
    .wake_grant (wake_grant),
    .trc_en_in  (trc_en_in),
    .trc_tick   (trc_tick)
);

// File: tb/dbg_port_ctl_tb.sv
module dbg_port_ctl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       slp_req = 1'b0, wake_req = 1'b0;
    logic       slp_grant, wake_grant;
    logic       trc_en_in = 1'b0;
    logic       trc_tick, evt_port_en, pstat_mode, msg_ok, div_rsv;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Reference model state
    int m_evt = 0, m_lpd = 0, m_pst = 0, m_div = 0;
    int m_st = 0;   // 0 awake, 1 entry pending, 2 asleep, 3 exit pending
    int m_sg = 0, m_wg = 0;
    int m_cnt = 0, m_per = 1;
    int tick_cnt = 0;

    always #10 clk = ~clk;

    dbg_port_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .slp_req(slp_req), .wake_req(wake_req),
        .slp_grant(slp_grant), .wake_grant(wake_grant), .trc_en_in(trc_en_in),
        .trc_tick(trc_tick), .evt_port_en(evt_port_en), .pstat_mode(pstat_mode),
        .msg_ok(msg_ok), .div_rsv(div_rsv)
    );

    function automatic int ratio_of(int code);
        case (code)
            0: return 1;
            1: return 2;
            3: return 4;
            default: return 8;
        endcase
    endfunction

    function automatic int exp_tick();
        return (trc_en_in && m_cnt == m_per - 1) ? 1 : 0;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_step();
        int tk;
        tk = exp_tick();
        if (!trc_en_in || tk == 1) begin
            m_cnt = 0;
            m_per = ratio_of(m_div);
        end else begin
            m_cnt++;
        end
        m_sg = 0;
        m_wg = 0;
        case (m_st)
            0: if (slp_req) begin
                   if (m_lpd == 1) m_st = 1;
                   else begin m_st = 2; m_sg = 1; end
               end
            1: if (reg_wr && !reg_wdata[2]) begin m_st = 2; m_sg = 1; end
            2: if (wake_req) begin
                   if (m_lpd == 1) m_st = 3;
                   else begin m_st = 0; m_wg = 1; end
               end
            default: if (reg_wr && reg_wdata[2]) begin m_st = 0; m_wg = 1; end
        endcase
        if (reg_wr) begin
            m_evt = reg_wdata[0];
            m_lpd = reg_wdata[1];
            m_pst = reg_wdata[3];
            m_div = int'(reg_wdata[6:4]);
        end
    endtask

    task automatic compare_all();
        int rd;
        rd = m_evt | (m_lpd << 1) | ((m_st == 1 ? 1 : 0) << 2) | (m_pst << 3) | (m_div << 4);
        chk("R2 readback", int'(reg_rdata), rd);
        chk("R12 slp_grant", int'(slp_grant), m_sg);
        chk("R12 wake_grant", int'(wake_grant), m_wg);
        chk("R2 evt_port_en", int'(evt_port_en), m_evt);
        chk("R2 pstat_mode", int'(pstat_mode), m_pst);
        chk("R8 msg_ok", int'(msg_ok), 1 - m_pst);
        chk("R10 div_rsv", int'(div_rsv), (ratio_of(m_div) == 8 && m_div != 7) ? 1 : 0);
        chk("R9 trc_tick", int'(trc_tick), exp_tick());
    endtask

    task automatic cyc();
        @(posedge clk);
        if (rst_n) model_step();
        @(negedge clk);
        if (trc_tick) tick_cnt++;
        compare_all();
    endtask

    task automatic wr(logic [7:0] d);
        reg_wr = 1'b1;
        reg_wdata = d;
        cyc();
        reg_wr = 1'b0;
    endtask

    task automatic run_div(logic [7:0] d, int exp_ticks, string req);
        wr(d);
        repeat (8) cyc();
        tick_cnt = 0;
        repeat (32) cyc();
        chk(req, tick_cnt, exp_ticks);
    endtask

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        // R1 reset state
        chk("R1 reset readback", int'(reg_rdata), 0);
        chk("R1 no grant", int'(slp_grant | wake_grant), 0);

        // R2, R8: field writes
        wr(8'h89);
        chk("R2 bit7 reads 0", int'(reg_rdata[7]), 0);
        chk("R2 evt enable", int'(evt_port_en), 1);
        chk("R8 msg blocked", int'(msg_ok), 0);
        wr(8'h00);
        chk("R8 msg allowed", int'(msg_ok), 1);

        // R7: sync write in awake idle has no effect
        wr(8'h04);
        chk("R7 sync idle", int'(reg_rdata[2]), 0);

        // R6: pass-through with low-power debug off
        slp_req = 1'b1;
        cyc();
        slp_req = 1'b0;
        chk("R6 sleep grant", int'(slp_grant), 1);
        cyc();
        chk("R12 sleep pulse ends", int'(slp_grant), 0);
        wake_req = 1'b1;
        cyc();
        wake_req = 1'b0;
        chk("R6 wake grant", int'(wake_grant), 1);
        cyc();

        // R3, R4: entry handshake
        wr(8'h02);
        slp_req = 1'b1;
        cyc();
        chk("R3 sync set", int'(reg_rdata[2]), 1);
        chk("R3 no grant", int'(slp_grant), 0);
        repeat (3) cyc();
        slp_req = 1'b0;
        wr(8'h06);
        chk("R4 still pending", int'(reg_rdata[2]), 1);
        wr(8'h02);
        chk("R4 sleep grant", int'(slp_grant), 1);
        chk("R4 sync cleared", int'(reg_rdata[2]), 0);
        cyc();

        // R7: sync write while asleep
        wr(8'h06);
        chk("R7 asleep no wake", int'(wake_grant), 0);
        chk("R7 asleep sync", int'(reg_rdata[2]), 0);

        // R5: exit handshake
        wake_req = 1'b1;
        cyc();
        wake_req = 1'b0;
        chk("R5 no grant yet", int'(wake_grant), 0);
        chk("R5 sync low", int'(reg_rdata[2]), 0);
        repeat (2) cyc();
        wr(8'h06);
        chk("R5 wake grant", int'(wake_grant), 1);
        chk("R5 sync stays 0", int'(reg_rdata[2]), 0);
        cyc();

        // R9, R10, R11: divider
        trc_en_in = 1'b1;
        run_div(8'h00, 32, "R9 div1");
        run_div(8'h10, 16, "R9 div2");
        run_div(8'h30, 8, "R9 div4");
        run_div(8'h70, 4, "R9 div8");
        run_div(8'h20, 4, "R10 reserved 010");
        chk("R10 rsv flag", int'(div_rsv), 1);
        run_div(8'h50, 4, "R10 reserved 101");
        // R11: change from /8 to /1 waits for the old boundary
        wr(8'h70);
        repeat (12) cyc();
        wr(8'h00);
        repeat (20) cyc();
        trc_en_in = 1'b0;
        cyc();
        tick_cnt = 0;
        repeat (16) cyc();
        chk("R11 gated", tick_cnt, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule